// File: doc/BRIEF.md
# Segmented Message Record/Playback Controller

This block is the digital sequencer of a single-chip voice recorder whose sample storage is divided into a fixed number of segments. A host, or a few switches, presents an active-low enable, a power-down level, a play/record select and an 8-bit start segment. On the falling edge of the enable the block captures the select and the address. It then walks a segment pointer forward once per "segment done" tick from the storage array, which is modelled here only as that tick.

Each segment has one end-of-message marker bit, held in registers. A record cycle clears the markers of the segments it passes over and sets a marker where it is stopped. A playback cycle stops at the first segment whose marker is set. Running past the last segment puts the block into an overflow state, and it stays there until power-down is raised. The block also drives an active-low end-of-message pulse, a speaker enable and a select that routes the auxiliary input to the speaker. A low-supply flag restricts the device to playback only.

Top module: `msg_seq_ctrl`

## Requirements
- R1: After reset the block is idle and `seg_ptr` is 0. `eom_n` is 1 while `low_supply` is 0. `spkr_en` is 1 while `pwr_dn` is 0. `aux_route`, `rec_active` and `play_active` are 0.
- R2: With `pwr_dn` low, a 1-to-0 transition of `chip_en_n` in the idle state captures `start_addr` and `play_sel`. One clock later `seg_ptr` equals the captured address, and `play_active` is 1 if `play_sel` was 1, or `rec_active` is 1 if it was 0.
- R3: While recording, each `seg_tick` clears the marker of the current segment and advances `seg_ptr` by one.
- R4: A record cycle ends one clock after `chip_en_n` or `pwr_dn` goes high, and the marker of the segment then held in `seg_ptr` is set.
- R5: While playing, `seg_tick` advances `seg_ptr`. In the first cycle in which the current segment's marker is set, playback ends, and `eom_n` goes low one clock later for exactly EOM_LEN clocks (default 8).
- R6: A `seg_tick` at segment SEGS-1 (default 159) during record or playback enters overflow. The same happens when the captured address is SEGS or more. On entry `eom_n` pulses low. In overflow, `seg_ptr` holds SEGS-1 (or its value on entry), `aux_route` is 1, and enable falling edges are ignored.
- R7: `pwr_dn` high returns the block to idle with `seg_ptr` equal to 0 one clock later, from any state, including overflow.
- R8: While `low_supply` is 1, `eom_n` is 0 and a captured record request leaves the block idle with `seg_ptr` unchanged. Playback requests are still accepted.
- R9: `spkr_en` is 0 while recording and while `pwr_dn` is 1.
- R10: `aux_route` is 1 when `chip_en_n` is high and the most recent playback cycle has ended, or when in overflow.
- R11: A marker left by an earlier recording inside a range that is recorded again is cleared, so playback runs on to the new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_n | input | 1 | Active-low enable; its falling edge starts a cycle |
| pwr_dn | input | 1 | Power-down; resets the pointer and ends any cycle |
| play_sel | input | 1 | 1 selects playback, 0 selects record |
| start_addr | input | 8 | Start segment |
| seg_tick | input | 1 | One-clock pulse when the storage finishes a segment |
| low_supply | input | 1 | Low-supply flag |
| eom_n | output | 1 | Active-low end-of-message / overflow indication |
| spkr_en | output | 1 | Speaker driver enable |
| aux_route | output | 1 | Route auxiliary input to speaker |
| seg_ptr | output | 8 | Current segment pointer |
| rec_active | output | 1 | Record cycle in progress |
| play_active | output | 1 | Playback cycle in progress |

## Verification
The hardest case to reach is the stale marker. It needs two overlapping recordings: the first leaves a marker in the middle of the range, and the second passes over it and stops further on. Then a playback must run across the old position without stopping. The stimulus records segments 10 to 13, then records 12 to 15 and ends it with power-down, and finally plays from 12 while checking that the pointer reaches 15. Overflow is reached by recording from segment 150 and holding the tick high through the last segment.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_PLAY = 2'd2,
        ST_OVF  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/msg_marker_bank.sv
module msg_marker_bank #(
    parameter int SEGS   = 160,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic              wr_val,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              rd_bit
);
    logic [SEGS-1:0] mark_d, mark_q;

    // One marker flop per segment; only the addressed bit may change.
    for (genvar g = 0; g < SEGS; g++) begin : g_mark
        always_comb begin
            mark_d[g] = mark_q[g];
            if (wr_en && (wr_idx == ADDR_W'(g))) begin
                mark_d[g] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mark_q <= '0;
        else        mark_q <= mark_d;
    end

    assign rd_bit = mark_q[rd_idx];
endmodule

// File: rtl/msg_eom_pulse.sv
module msg_eom_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire)              cnt_d = CW'(LEN);
        else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/msg_seq_ctrl.sv
module msg_seq_ctrl
    import msg_seq_pkg::*;
#(
    parameter int SEGS    = 160,
    parameter int ADDR_W  = 8,
    parameter int EOM_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              pwr_dn,
    input  logic              play_sel,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              seg_tick,
    input  logic              low_supply,
    output logic              eom_n,
    output logic              spkr_en,
    output logic              aux_route,
    output logic [ADDR_W-1:0] seg_ptr,
    output logic              rec_active,
    output logic              play_active
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(SEGS - 1);
    localparam logic [ADDR_W:0]   SEGS_W   = (ADDR_W + 1)'(SEGS);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic              ce_prev;
        logic              done;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              mk_we, mk_val, mk_hit;
    logic [ADDR_W-1:0] mk_idx;
    logic              eom_fire, eom_busy;
    logic              ce_fall, at_last, req_ok;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ce_prev = chip_en_n;
        mk_we         = 1'b0;
        mk_val        = 1'b0;
        mk_idx        = ctl_q.ptr;
        eom_fire      = 1'b0;
        ce_fall       = ctl_q.ce_prev && !chip_en_n;
        at_last       = (ctl_q.ptr == LAST_IDX);
        req_ok        = play_sel || !low_supply;

        if (pwr_dn) begin
            if (ctl_q.st == ST_REC) begin
                mk_we  = 1'b1;
                mk_val = 1'b1;
            end
            if (ctl_q.st == ST_PLAY) ctl_d.done = 1'b1;
            ctl_d.st  = ST_IDLE;
            ctl_d.ptr = '0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (ce_fall && req_ok) begin
                        ctl_d.done = 1'b0;
                        if ({1'b0, start_addr} >= SEGS_W) begin
                            ctl_d.st  = ST_OVF;
                            ctl_d.ptr = LAST_IDX;
                            eom_fire  = 1'b1;
                        end else begin
                            ctl_d.st  = play_sel ? ST_PLAY : ST_REC;
                            ctl_d.ptr = start_addr;
                        end
                    end
                end
                ST_REC: begin
                    if (chip_en_n) begin
                        mk_we    = 1'b1;
                        mk_val   = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end else if (seg_tick) begin
                        mk_we = 1'b1;
                        if (at_last) begin
                            ctl_d.st = ST_OVF;
                            eom_fire = 1'b1;
                        end else begin
                            ctl_d.ptr = ctl_q.ptr + ADDR_W'(1);
                        end
                    end
                end
                ST_PLAY: begin
                    if (chip_en_n) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else if (mk_hit) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        eom_fire   = 1'b1;
                    end else if (seg_tick) begin
                        if (at_last) begin
                            ctl_d.st = ST_OVF;
                            eom_fire = 1'b1;
                        end else begin
                            ctl_d.ptr = ctl_q.ptr + ADDR_W'(1);
                        end
                    end
                end
                default: ; // overflow: held until power-down
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.ptr     <= '0;
            ctl_q.ce_prev <= 1'b1;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    msg_marker_bank #(.SEGS(SEGS), .ADDR_W(ADDR_W)) u_marks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mk_we),
        .wr_idx (mk_idx),
        .wr_val (mk_val),
        .rd_idx (ctl_q.ptr),
        .rd_bit (mk_hit)
    );

    msg_eom_pulse #(.LEN(EOM_LEN)) u_eom (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (eom_fire),
        .active (eom_busy)
    );

    assign eom_n       = !(eom_busy || low_supply);
    assign spkr_en     = !pwr_dn && (ctl_q.st != ST_REC);
    assign aux_route   = (chip_en_n && ctl_q.done) || (ctl_q.st == ST_OVF);
    assign seg_ptr     = ctl_q.ptr;
    assign rec_active  = (ctl_q.st == ST_REC);
    assign play_active = (ctl_q.st == ST_PLAY);
endmodule

// File: rtl/msg_seq_ctrl_chk.sv
module msg_seq_ctrl_chk #(
    parameter int SEGS   = 160,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn,
    input logic              low_supply,
    input logic              eom_n,
    input logic              spkr_en,
    input logic [ADDR_W-1:0] seg_ptr,
    input logic              rec_active,
    input logic              play_active
);
    localparam logic [ADDR_W:0] SEGS_W = (ADDR_W + 1)'(SEGS);

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, seg_ptr} < SEGS_W);

    p_pd_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (seg_ptr == '0) && !rec_active && !play_active);

    p_lowsup_eom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |-> !eom_n);

    p_lowsup_norec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (low_supply && !rec_active) |=> !rec_active);

    p_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_active || pwr_dn) |-> !spkr_en);

    p_one_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_active && play_active));
endmodule

bind msg_seq_ctrl msg_seq_ctrl_chk #(.SEGS(SEGS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .low_supply  (low_supply),
    .eom_n       (eom_n),
    .spkr_en     (spkr_en),
    .seg_ptr     (seg_ptr),
    .rec_active  (rec_active),
    .play_active (play_active)
);

// File: tb/msg_seq_ctrl_tb.sv
module msg_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, pd = 1'b0, psel = 1'b0, tick = 1'b0, lows = 1'b0;
    logic [7:0] addr = '0;
    logic       eom_n, spkr_en, aux_route, rec_active, play_active;
    logic [7:0] seg_ptr;

    always #5 clk = ~clk;

    msg_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .pwr_dn(pd),
        .play_sel(psel), .start_addr(addr), .seg_tick(tick),
        .low_supply(lows), .eom_n(eom_n), .spkr_en(spkr_en),
        .aux_route(aux_route), .seg_ptr(seg_ptr),
        .rec_active(rec_active), .play_active(play_active)
    );

    localparam int F_PTR = 0, F_EOM = 1, F_SPK = 2, F_AUX = 3, F_REC = 4, F_PLAY = 5;

    typedef struct {
        int    due;
        int    fld;
        int    val;
        string req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    function automatic int observe(int fld);
        case (fld)
            F_PTR:   return int'(seg_ptr);
            F_EOM:   return int'(eom_n);
            F_SPK:   return int'(spkr_en);
            F_AUX:   return int'(aux_route);
            F_REC:   return int'(rec_active);
            default: return int'(play_active);
        endcase
    endfunction

    // Monitor: compares due items shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    checks++;
                    if (observe(sb[i].fld) != sb[i].val) begin
                        errors++;
                        $display("FAIL %s field %0d cycle %0d actual %0d expected %0d",
                                 sb[i].req, sb[i].fld, cyc, observe(sb[i].fld), sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic expect_at(int ofs, int fld, int val, string req);
        item_t it;
        it.due = cyc + ofs;
        it.fld = fld;
        it.val = val;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(logic play, logic [7:0] a);
        ce_n = 1'b1;
        step(1);
        psel = play;
        addr = a;
        ce_n = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, F_PTR, 0, "R1");
        expect_at(1, F_EOM, 1, "R1");
        expect_at(1, F_SPK, 1, "R1");
        expect_at(1, F_AUX, 0, "R1");
        expect_at(1, F_REC, 0, "R1");
        expect_at(1, F_PLAY, 0, "R1");
        step(2);

        // Record segments 10..13, stopped by enable
        start(1'b0, 8'd10);
        expect_at(1, F_REC, 1, "R2");
        expect_at(1, F_PTR, 10, "R2");
        expect_at(1, F_SPK, 0, "R9");
        step(1);
        tick = 1'b1;
        expect_at(3, F_PTR, 13, "R3");
        step(3);
        tick = 1'b0;
        ce_n = 1'b1;
        expect_at(1, F_REC, 0, "R4");
        expect_at(1, F_SPK, 1, "R9");
        step(1);

        // Play from 10, stops on the marker at 13
        start(1'b1, 8'd10);
        expect_at(1, F_PLAY, 1, "R2");
        expect_at(1, F_PTR, 10, "R2");
        step(1);
        tick = 1'b1;
        expect_at(3, F_PTR, 13, "R5");
        expect_at(3, F_PLAY, 1, "R5");
        step(3);
        tick = 1'b0;
        expect_at(1, F_PLAY, 0, "R5");
        expect_at(1, F_EOM, 0, "R5");
        expect_at(1, F_AUX, 0, "R10");
        expect_at(8, F_EOM, 0, "R5");
        expect_at(9, F_EOM, 1, "R5");
        step(9);
        ce_n = 1'b1;
        expect_at(1, F_AUX, 1, "R10");
        step(1);

        // Re-record 12..15 over the old marker, stopped by power-down
        start(1'b0, 8'd12);
        step(1);
        tick = 1'b1;
        step(3);
        tick = 1'b0;
        pd = 1'b1;
        expect_at(1, F_PTR, 0, "R7");
        expect_at(1, F_REC, 0, "R4");
        expect_at(1, F_SPK, 0, "R9");
        step(1);
        pd = 1'b0;
        step(1);
        start(1'b1, 8'd12);
        step(1);
        tick = 1'b1;
        expect_at(3, F_PTR, 15, "R11");
        expect_at(3, F_PLAY, 1, "R11");
        step(3);
        tick = 1'b0;
        expect_at(1, F_PLAY, 0, "R11");
        expect_at(1, F_EOM, 0, "R11");
        step(1);

        // Low supply: record refused, playback accepted
        ce_n = 1'b1;
        lows = 1'b1;
        expect_at(1, F_EOM, 0, "R8");
        step(1);
        start(1'b0, 8'd40);
        expect_at(1, F_REC, 0, "R8");
        expect_at(1, F_PTR, 15, "R8");
        step(1);
        start(1'b1, 8'd30);
        expect_at(1, F_PLAY, 1, "R8");
        expect_at(1, F_PTR, 30, "R8");
        step(1);
        ce_n = 1'b1;
        step(12);
        lows = 1'b0;
        expect_at(1, F_EOM, 1, "R8");
        step(1);

        // Overflow while recording from 150
        start(1'b0, 8'd150);
        step(1);
        tick = 1'b1;
        expect_at(9, F_PTR, 159, "R6");
        expect_at(9, F_REC, 1, "R6");
        step(9);
        expect_at(1, F_REC, 0, "R6");
        expect_at(1, F_EOM, 0, "R6");
        expect_at(1, F_AUX, 1, "R6");
        expect_at(1, F_PTR, 159, "R6");
        step(1);
        tick = 1'b0;
        start(1'b1, 8'd5);
        expect_at(1, F_PLAY, 0, "R6");
        expect_at(1, F_PTR, 159, "R6");
        step(1);
        pd = 1'b1;
        expect_at(1, F_PTR, 0, "R7");
        expect_at(1, F_AUX, 0, "R7");
        step(1);
        pd = 1'b0;
        step(1);

        // Start address beyond the last segment
        start(1'b1, 8'd200);
        expect_at(1, F_AUX, 1, "R6");
        expect_at(1, F_EOM, 0, "R6");
        expect_at(1, F_PLAY, 0, "R6");
        step(1);
        pd = 1'b1;
        expect_at(1, F_PTR, 0, "R7");
        step(1);
        pd = 1'b0;
        ce_n = 1'b1;
        step(12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule